// File: doc/BRIEF.md
# Vectored Interrupt Manager

This block collects a bank of interrupt request lines and turns each rising edge into a sticky pending bit. A per-channel enable mask gates the pending bits. A priority encoder then keeps picking the most urgent enabled pending channel. Software sees the outcome through two registers on a small read port: an index register and a vector-address register. The vector-address register is looked up in a writable table that holds one address per channel.

The index register follows the pending set on every cycle. The vector register trails it by two cycles. In hardware-vectored operation the CPU raises an acknowledge line when it is ready to fetch its handler. The block answers with address-valid and holds the vector output steady until acknowledge falls. During that hold the index register keeps moving, so it can name a different source than the held vector.

Which access retires a serviced request depends on the operating mode. In index mode it is a read of the index register. In register-vectored mode it is a read of the vector register. In hardware-vectored mode it is the rising edge of acknowledge.

Top module: `ivm_top`

## Requirements
- R1: A pending bit is set only on a 0-to-1 transition of its request line. A line that stays high after its bit has been retired does not set the bit again.
- R2: The index register holds the number of the lowest-numbered channel that is both pending and enabled, plus one. Channel 0 has the highest priority. The index register reflects the pending set one cycle after that set changes.
- R3: After reset, and whenever no enabled channel is pending, the index register reads 0. After reset the vector register, irqOut and addrValid are also 0.
- R4: irqOut is high exactly when the index register is nonzero. It rises two clock edges after the edge on which a request line is first sampled high.
- R5: The vector register holds table entry (index-1), or 0 when the index is 0. It changes two clock edges after the index register changes.
- R6: A higher-priority request that arrives while a lower one is waiting replaces it in the index register and then in the vector register.
- R7: In hardware-vectored mode (mode 2), addrValid goes high on the edge after ack is first sampled high and stays high while ack stays high. vecAddr does not change during that time.
- R8: While vecAddr is held, the index register keeps tracking newly pending channels.
- R9: Mode encoding: 0 is index mode, 1 is register-vectored, 2 is hardware-vectored, and 3 behaves as index mode. rdSel 0 selects the index register and rdSel 1 selects the vector register. In index mode, a read of the index register (rdEn with rdSel 0) retires the channel it reports. The index register drops on the second edge after the read.
- R10: In register-vectored mode, a vector read retires the channel the vector register names. An index read retires nothing.
- R11: In hardware-vectored mode, the rising edge of ack retires the channel named by the held vector. Register reads retire nothing.
- R12: A pending channel whose enable bit is 0 is ignored by the priority choice but stays pending. It is reported once it is enabled.
- R13: A table write (tblWe, tblIdx, tblData) changes the address that the vector register shows for that channel.
- R14: If a channel is retired on the same edge as a new rising edge of its line, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_CH | Request lines, one per channel |
| enMask | input | NUM_CH | Per-channel enable |
| mode | input | 2 | Operating mode (0 index, 1 register-vectored, 2 hardware-vectored, 3 as 0) |
| rdEn | input | 1 | Register read strobe |
| rdSel | input | 1 | 0 index register, 1 vector register |
| rdData | output | ADDR_W | Read data, valid in the cycle of rdEn |
| tblWe | input | 1 | Vector table write enable |
| tblIdx | input | CH_W | Table entry to write |
| tblData | input | ADDR_W | Address to write |
| irqOut | output | 1 | Interrupt request toward the CPU |
| ack | input | 1 | CPU ready-to-fetch acknowledge |
| addrValid | output | 1 | Vector address valid toward the CPU |
| vecAddr | output | ADDR_W | Vector address toward the CPU |

## Verification
Two things can hit the same pending bit on the same edge: the retire strobe from a register read or from ack, and a fresh rising edge on that channel's line. The bench provokes this by reading the index register in the same cycle that it raises the reported channel's line again. It then requires the index to still name that channel two edges later. A second overlap is checked as well. A new, more urgent request arrives while the vector is held under ack. The bench requires the index to move to the new channel while vecAddr keeps the held address.

// File: rtl/ivm_pkg.sv
package ivm_pkg;

  localparam logic [1:0] MODE_INDEX = 2'd0;
  localparam logic [1:0] MODE_REGVEC = 2'd1;
  localparam logic [1:0] MODE_HWVEC = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;   // retire the channel named by the index register
    logic clrVec;   // retire the channel named by the vector register
    logic freeze;   // hold the vector register
  } ivmStrobe_t;

endpackage

// File: rtl/ivm_ctrl.sv
module ivm_ctrl
  import ivm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       rdEn,
  input  logic       rdSel,
  input  logic       ack,
  output ivmStrobe_t strb,
  output logic       addrValid
);

  logic ackPrev;
  logic isHw;
  logic isReg;
  logic isIdx;

  assign isHw  = (mode == MODE_HWVEC);
  assign isReg = (mode == MODE_REGVEC);
  assign isIdx = !isHw && !isReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev   <= 1'b0;
      addrValid <= 1'b0;
    end else begin
      ackPrev   <= ack;
      addrValid <= isHw && ack;
    end
  end

  always_comb begin
    strb.clrIdx = isIdx && rdEn && !rdSel;
    strb.clrVec = (isReg && rdEn && rdSel) || (isHw && ack && !ackPrev);
    strb.freeze = isHw && ack;
  end

endmodule

// File: rtl/ivm_datapath.sv
module ivm_datapath
  import ivm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NUM_CH + 1),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqReq,
  input  logic [NUM_CH-1:0] enMask,
  input  ivmStrobe_t        strb,
  input  logic              tblWe,
  input  logic [CH_W-1:0]   tblIdx,
  input  logic [ADDR_W-1:0] tblData,
  output logic [IDX_W-1:0]  idxReg,
  output logic [IDX_W-1:0]  vecIdx,
  output logic [ADDR_W-1:0] vecReg,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] rise,
  output logic [NUM_CH-1:0] maskedPend
);

  logic [NUM_CH-1:0] reqPrev;
  logic [NUM_CH-1:0] clrMask;
  logic [IDX_W-1:0]  idxNext;
  logic [IDX_W-1:0]  idxD1;
  logic [ADDR_W-1:0] vecLookup;
  logic [ADDR_W-1:0] vecTable [NUM_CH];

  assign rise       = irqReq & ~reqPrev;
  assign maskedPend = pending & enMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= irqReq;
  end

  // per-channel pending bit and table entry
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clrMask[c] = (strb.clrIdx && idxReg == IDX_W'(c + 1)) ||
                        (strb.clrVec && vecIdx == IDX_W'(c + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pending[c] <= 1'b0;
      else       pending[c] <= (pending[c] && !clrMask[c]) || rise[c];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  vecTable[c] <= '0;
      else if (tblWe && tblIdx == CH_W'(c))       vecTable[c] <= tblData;
    end
  end

  // lowest channel number wins
  always_comb begin
    idxNext = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (maskedPend[c]) idxNext = IDX_W'(c + 1);
    end
  end

  always_comb begin
    vecLookup = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idxD1 == IDX_W'(c + 1)) vecLookup = vecTable[c];
    end
  end

  // index, one delay stage, then the vector register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      idxD1  <= '0;
      vecIdx <= '0;
      vecReg <= '0;
    end else begin
      idxReg <= idxNext;
      idxD1  <= idxReg;
      if (!strb.freeze) begin
        vecIdx <= idxD1;
        vecReg <= vecLookup;
      end
    end
  end

endmodule

// File: rtl/ivm_top.sv
module ivm_top
  import ivm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NUM_CH + 1),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqReq,
  input  logic [NUM_CH-1:0] enMask,
  input  logic [1:0]        mode,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic              tblWe,
  input  logic [CH_W-1:0]   tblIdx,
  input  logic [ADDR_W-1:0] tblData,
  output logic              irqOut,
  input  logic              ack,
  output logic              addrValid,
  output logic [ADDR_W-1:0] vecAddr
);

  ivmStrobe_t        strb;
  logic [IDX_W-1:0]  idxReg;
  logic [IDX_W-1:0]  vecIdx;
  logic [ADDR_W-1:0] vecReg;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] maskedPend;

  ivm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .rdEn      (rdEn),
    .rdSel     (rdSel),
    .ack       (ack),
    .strb      (strb),
    .addrValid (addrValid)
  );

  ivm_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .enMask     (enMask),
    .strb       (strb),
    .tblWe      (tblWe),
    .tblIdx     (tblIdx),
    .tblData    (tblData),
    .idxReg     (idxReg),
    .vecIdx     (vecIdx),
    .vecReg     (vecReg),
    .pending    (pending),
    .rise       (rise),
    .maskedPend (maskedPend)
  );

  assign rdData  = rdSel ? vecReg : ADDR_W'(idxReg);
  assign irqOut  = (idxReg != '0);
  assign vecAddr = vecReg;

endmodule

// File: rtl/ivm_checker.sv
module ivm_checker #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic              ack,
  input logic              addrValid,
  input logic [ADDR_W-1:0] vecAddr,
  input logic [IDX_W-1:0]  idxReg,
  input logic [IDX_W-1:0]  vecIdx,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] rise,
  input logic [NUM_CH-1:0] maskedPend
);

  logic [1:0] sinceRst;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign armed = (sinceRst >= 2'd2);

  // R5: vector follows the index two edges later unless held
  p_vec_lag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(mode == 2'd2 && ack)) |-> (vecIdx == $past(idxReg, 2)));

  // R7: held vector does not move
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(mode == 2'd2 && ack)) |-> $stable(vecAddr));

  // R7: address-valid only answers an acknowledge in hardware mode
  p_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && addrValid) |-> ($past(ack) && $past(mode) == 2'd2));

  // R3: nothing enabled pending means a zero index next cycle
  p_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(maskedPend == '0)) |-> (idxReg == '0));

  // R2: channel 0 wins whenever it is enabled and pending
  p_pick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(maskedPend[0])) |-> (idxReg == IDX_W'(1)));

  // R14: a rising edge always leaves the bit pending
  for (genvar c = 0; c < NUM_CH; c++) begin : g_set
    p_set_wins_r14: assert property (@(posedge clk) disable iff (!rstN)
      (armed && $past(rise[c])) |-> pending[c]);
  end

endmodule

bind ivm_top ivm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .mode       (mode),
  .ack        (ack),
  .addrValid  (addrValid),
  .vecAddr    (vecAddr),
  .idxReg     (idxReg),
  .vecIdx     (vecIdx),
  .pending    (pending),
  .rise       (rise),
  .maskedPend (maskedPend)
);

// File: tb/sim_ivm_top.sv
`timescale 1ns/1ps
module sim_ivm_top;

  localparam int NUM_CH = 8;
  localparam int ADDR_W = 32;
  localparam int CH_W   = $clog2(NUM_CH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] irqReq = '0;
  logic [NUM_CH-1:0] enMask = '1;
  logic [1:0]        mode = 2'd0;
  logic              rdEn = 1'b0;
  logic              rdSel = 1'b0;
  logic [ADDR_W-1:0] rdData;
  logic              tblWe = 1'b0;
  logic [CH_W-1:0]   tblIdx = '0;
  logic [ADDR_W-1:0] tblData = '0;
  logic              irqOut;
  logic              ack = 1'b0;
  logic              addrValid;
  logic [ADDR_W-1:0] vecAddr;

  int total = 0;
  int failed = 0;
  bit done = 0;
  logic [ADDR_W-1:0] expTbl [NUM_CH];

  always #2.5 clk = ~clk;

  ivm_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .enMask(enMask), .mode(mode),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .tblWe(tblWe), .tblIdx(tblIdx),
    .tblData(tblData), .irqOut(irqOut), .ack(ack), .addrValid(addrValid),
    .vecAddr(vecAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peekIdx(output logic [31:0] v);
    rdEn = 1'b0; rdSel = 1'b0; #1 v = rdData;
  endtask

  task automatic peekVec(output logic [31:0] v);
    rdEn = 1'b0; rdSel = 1'b1; #1 v = rdData;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] v);
    rdSel = sel; rdEn = 1'b1; #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulse(input int c);
    irqReq[c] = 1'b1; step(1); irqReq[c] = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    step(3);
    rstN = 1'b1;
    step(1);
    peekIdx(v); chk("R3 reset index", v, 0);
    peekVec(v); chk("R3 reset vector", v, 0);
    chk("R3 reset irqOut", 32'(irqOut), 0);
    chk("R3 reset addrValid", 32'(addrValid), 0);

    for (int c = 0; c < NUM_CH; c++) begin
      expTbl[c] = 32'h2000_0000 + 32'(c) * 32'h100 + 32'h4;
      tblWe = 1'b1; tblIdx = CH_W'(c); tblData = expTbl[c]; step(1);
    end
    tblWe = 1'b0;

    // single channels, line held high (level source)
    for (int c = 0; c < NUM_CH; c++) begin
      irqReq[c] = 1'b1;
      step(2);
      peekIdx(v); chk("R2 single index", v, 32'(c + 1));
      chk("R4 irqOut high", 32'(irqOut), 1);
      step(2);
      peekVec(v); chk("R5 vector entry", v, expTbl[c]);
      readReg(1'b0, v); chk("R9 read returns index", v, 32'(c + 1));
      step(2);
      peekIdx(v); chk("R9/R1 retired, level line does not reset", v, 0);
      chk("R4 irqOut low", 32'(irqOut), 0);
      irqReq[c] = 1'b0;
      step(1);
    end

    // priority over all pairs
    for (int a = 0; a < NUM_CH; a++) begin
      for (int b = a + 1; b < NUM_CH; b++) begin
        irqReq[a] = 1'b1; irqReq[b] = 1'b1;
        step(2);
        peekIdx(v); chk("R2 pair winner", v, 32'(a + 1));
        readReg(1'b0, v); step(2);
        peekIdx(v); chk("R2 pair second", v, 32'(b + 1));
        readReg(1'b0, v); step(2);
        peekIdx(v); chk("R3 pair drained", v, 0);
        irqReq[a] = 1'b0; irqReq[b] = 1'b0;
        step(1);
      end
    end

    // vector lag and preemption
    pulse(5); step(1);
    peekIdx(v); chk("R5 index first", v, 6);
    peekVec(v); chk("R5 vector lags", v, 0);
    step(1);
    peekVec(v); chk("R5 vector still lags", v, 0);
    step(1);
    peekVec(v); chk("R5 vector arrives", v, expTbl[5]);
    pulse(1); step(1);
    peekIdx(v); chk("R6 preempt index", v, 2);
    step(2);
    peekVec(v); chk("R6 preempt vector", v, expTbl[1]);
    readReg(1'b0, v); step(2);
    peekIdx(v); chk("R6 older resumes", v, 6);
    readReg(1'b0, v); step(2);

    // mask
    enMask[2] = 1'b0;
    pulse(2); step(3);
    peekIdx(v); chk("R12 masked ignored", v, 0);
    chk("R12 masked irqOut", 32'(irqOut), 0);
    enMask[2] = 1'b1; step(1);
    peekIdx(v); chk("R12 kept pending", v, 3);
    readReg(1'b0, v); step(2);

    // table rewrite
    expTbl[7] = 32'hCAFE_0010;
    tblWe = 1'b1; tblIdx = CH_W'(7); tblData = expTbl[7]; step(1); tblWe = 1'b0;
    pulse(7); step(3);
    peekVec(v); chk("R13 rewritten entry", v, expTbl[7]);
    readReg(1'b0, v); step(2);

    // mode 3 behaves as index mode
    mode = 2'd3;
    pulse(6); step(1);
    readReg(1'b0, v); chk("R9 mode3 read", v, 7);
    step(2);
    peekIdx(v); chk("R9 mode3 retired", v, 0);

    // register-vectored
    mode = 2'd1;
    pulse(3); pulse(4); step(1);
    readReg(1'b0, v); chk("R10 index read", v, 4);
    step(2);
    peekIdx(v); chk("R10 index read retires nothing", v, 4);
    peekVec(v); chk("R10 vector shows ch3", v, expTbl[3]);
    readReg(1'b1, v); step(2);
    peekIdx(v); chk("R10 vector read retires", v, 5);
    step(2);
    readReg(1'b1, v); chk("R10 vector ch4", v, expTbl[4]);
    step(2);
    peekIdx(v); chk("R10 drained", v, 0);
    step(2);

    // hardware-vectored
    mode = 2'd2;
    pulse(4); step(3);
    peekVec(v); chk("R5 hw vector", v, expTbl[4]);
    chk("R7 addrValid idle", 32'(addrValid), 0);
    readReg(1'b0, v); step(2);
    peekIdx(v); chk("R11 read retires nothing", v, 5);
    ack = 1'b1; step(1);
    chk("R7 addrValid up", 32'(addrValid), 1);
    chk("R7 held address", vecAddr, expTbl[4]);
    pulse(0); step(1);
    peekIdx(v); chk("R8 index tracks during hold", v, 1);
    chk("R7 still held", vecAddr, expTbl[4]);
    step(3);
    chk("R7 held later", vecAddr, expTbl[4]);
    chk("R7 addrValid held", 32'(addrValid), 1);
    ack = 1'b0; step(1);
    chk("R7 addrValid down", 32'(addrValid), 0);
    step(2);
    chk("R5 released vector", vecAddr, expTbl[0]);
    ack = 1'b1; step(1); ack = 1'b0; step(2);
    peekIdx(v); chk("R11 ack retired both", v, 0);

    // retire and new edge on the same cycle
    mode = 2'd0;
    pulse(2); step(1);
    peekIdx(v); chk("R14 setup", v, 3);
    irqReq[2] = 1'b1;
    readReg(1'b0, v);
    step(2);
    peekIdx(v); chk("R14 set wins", v, 3);
    readReg(1'b0, v); step(2);
    peekIdx(v); chk("R14 later retire", v, 0);
    irqReq[2] = 1'b0;
    step(2);

    summary();
  end

endmodule